// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K words by 32 bits. The RAM is built from four 8-bit lanes. Each lane has its own active-low chip select and, in the default variant, its own active-low write enable. All four lanes share one active-low output enable. The host makes one request at a time. A request carries a word address, a lane mask, a width mode, a direction and the write data. The controller then steps the RAM strobes through address setup, an active phase and recovery. The length of each phase is a parameter counted in clock cycles.

The width mode states which lane masks are legal. Byte mode allows exactly one lane. Half-word mode allows the low pair or the high pair. Word mode allows all four lanes. A request whose mask does not fit its mode is refused with an error pulse and never reaches the RAM. The address only changes while no lane has its chip select and its write enable low together. The data driver is kept off the bus during and just after any read.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and in every idle cycle between transactions, the outputs are as follows. All `mem_cs_n_o` bits are 1, all `mem_we_n_o` bits are 1, `mem_oe_n_o` is 1, `mem_dq_oe_o` is 0 and `ready_o` is 1.
- R2: Width mode encoding on `mode_i` is 0 = byte, 1 = half-word and 2 = word; code 3 is reserved. Legal masks are:
  - byte mode: any mask with exactly one bit set;
  - half-word mode: 4'b0011 or 4'b1100;
  - word mode: 4'b1111.
  Mask bit i selects `mem_cs_n_o[i]` and data bits [8i+7:8i]. The number of chip selects low at once is always 0, 1, 2 or 4.
- R3: A write runs through three phases:
  - Setup: SETUP_CYC cycles with the address on `mem_addr_o`, all strobes high and the data driver on.
  - Pulse: PULSE_CYC cycles in which the chip selects of the selected lanes and their write enables are low together, with the write data on `mem_dq_o`.
  - Recovery: RECOV_CYC cycles with all strobes high.
- R4: `mem_addr_o` changes only on a clock edge where no lane has both its chip select and its write enable low, either in the cycle before that edge or in the cycle after it.
- R5: A read runs through the following steps:
  - Setup: SETUP_CYC cycles with all strobes high.
  - Access: ACCESS_CYC cycles with the selected chip selects low, `mem_oe_n_o` low and every write enable high.
  - Capture and return: the data is sampled on the last access edge. It is returned on `rdata_o` with a one-cycle `rvalid_o` pulse in the first recovery cycle. Lanes that were not selected read as zero.
- R6: A write changes only the RAM lanes selected by its mask. The other lanes of that word keep their contents.
- R7: A request with an illegal mask, or with mode 3, is refused. `err_o` is high for exactly the one cycle after the request is taken. No strobe falls, the data driver stays off and the RAM contents are unchanged.
- R8: `mem_dq_oe_o` is 1 only during the phases of a write. It is never 1 while `mem_oe_n_o` is 0, and never 1 in the cycle right after a cycle with `mem_oe_n_o` at 0.
- R9: The write-enable layout depends on SPLIT_WE:
  - SPLIT_WE = 1: each lane's write enable falls together with that lane's chip select.
  - SPLIT_WE = 0: all four write enable bits fall together during every write pulse and are otherwise high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request, taken on a clock edge while `ready_o` is high |
| we_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 2 | Width mode: 0 byte, 1 half-word, 2 word |
| addr_i | input | 17 | Word address |
| mask_i | input | 4 | Lane mask, bit i selects data bits [8i+7:8i] |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Controller idle, can take a request |
| err_o | output | 1 | One-cycle pulse for a refused request |
| rdata_o | output | 32 | Read data, unselected lanes zero |
| rvalid_o | output | 1 | One-cycle pulse, `rdata_o` valid |
| mem_addr_o | output | 17 | RAM address |
| mem_cs_n_o | output | 4 | RAM chip selects, one per lane, active low |
| mem_we_n_o | output | 4 | RAM write enables, active low |
| mem_oe_n_o | output | 1 | RAM shared output enable, active low |
| mem_dq_o | output | 32 | Data driven to the RAM |
| mem_dq_oe_o | output | 1 | Enable of the data driver |
| mem_dq_i | input | 32 | Data read from the RAM |

## Verification
Two functions can fall in the same cycle. One is the end of a read: `mem_oe_n_o` rising, with the read data returned on `rvalid_o`. The other is the start of a write that the host holds ready for the very next idle cycle. The bench provokes this by issuing a write in the same half cycle in which it finds the controller idle after a read, so the bus turnaround is as short as the controller allows. A monitor watches every cycle to judge that the data driver never turns on while the output enable is low, or in the cycle after. The scoreboard meanwhile checks that the read data was captured from the read's own address before the write replaced it.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_PULSE  = 3'd2,
    PH_ACCESS = 3'd3,
    PH_RECOV  = 3'd4
  } phase_e;

  localparam logic [1:0] MODE_BYTE = 2'd0;
  localparam logic [1:0] MODE_HALF = 2'd1;
  localparam logic [1:0] MODE_WORD = 2'd2;

endpackage

// File: rtl/sram_lane_decode.sv
module sram_lane_decode #(
  parameter int LANES = 4
) (
  input  logic [1:0]       mode_i,
  input  logic [LANES-1:0] mask_i,
  output logic             legal_o
);
  import sram_lane_pkg::*;

  localparam int PAIRS = LANES / 2;

  logic [PAIRS-1:0] pair_hit;

  // a half-word request must name exactly one aligned lane pair
  genvar p;
  generate
    for (p = 0; p < PAIRS; p++) begin : g_pair
      assign pair_hit[p] = (mask_i == (LANES'(2'b11) << (2 * p)));
    end
  endgenerate

  always_comb begin
    case (mode_i)
      MODE_BYTE: legal_o = $onehot(mask_i);
      MODE_HALF: legal_o = |pair_hit;
      MODE_WORD: legal_o = &mask_i;
      default:   legal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq #(
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int ACCESS_CYC = 2,
  parameter int RECOV_CYC  = 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic                    legal_i,
  output logic                    ready_o,
  output logic                    accept_o,
  output logic                    err_o,
  output logic                    capture_o,
  output sram_lane_pkg::phase_e   phase_d_o,
  output logic                    wr_d_o
);
  import sram_lane_pkg::*;

  localparam int MAX_SP  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_AR  = (ACCESS_CYC > RECOV_CYC) ? ACCESS_CYC : RECOV_CYC;
  localparam int MAX_CYC = (MAX_SP > MAX_AR) ? MAX_SP : MAX_AR;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LD_SETUP  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PULSE  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_ACCESS = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] LD_RECOV  = CNT_W'(RECOV_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic             err_q, err_d;
  logic             seq_en;
  logic             last_cyc;

  assign last_cyc = (cnt_q == '0);
  assign seq_en   = (phase_q != PH_IDLE) | req_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    err_d   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (req_i) begin
          if (legal_i) begin
            phase_d = PH_SETUP;
            cnt_d   = LD_SETUP;
            wr_d    = we_i;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      PH_SETUP: begin
        if (last_cyc) begin
          phase_d = wr_q ? PH_PULSE : PH_ACCESS;
          cnt_d   = wr_q ? LD_PULSE : LD_ACCESS;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_PULSE, PH_ACCESS: begin
        if (last_cyc) begin
          phase_d = PH_RECOV;
          cnt_d   = LD_RECOV;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_RECOV: begin
        if (last_cyc) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign ready_o   = (phase_q == PH_IDLE);
  assign accept_o  = (phase_q == PH_IDLE) & req_i & legal_i;
  assign capture_o = (phase_q == PH_ACCESS) & last_cyc;
  assign err_o     = err_q;
  assign phase_d_o = seq_en ? phase_d : phase_q;
  assign wr_d_o    = seq_en ? wr_d : wr_q;

  AST_ERR_LEAVES_IDLE_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (phase_q == PH_IDLE)); // R7
  AST_REFUSED_NOT_STARTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i && !legal_i) |=> (phase_q == PH_IDLE)); // R7
  AST_SETUP_BEFORE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_PULSE || phase_q == PH_ACCESS) && !$stable(phase_q)) |->
      ($past(phase_q) == PH_SETUP)); // R3
endmodule

// File: rtl/sram_lane_io.sv
module sram_lane_io #(
  parameter int ADDR_W   = 17,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter bit SPLIT_WE = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      accept_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [LANES-1:0]          mask_i,
  input  logic [LANES*LANE_W-1:0]   wdata_i,
  input  sram_lane_pkg::phase_e     phase_d_i,
  input  logic                      wr_d_i,
  input  logic                      capture_i,
  input  logic [LANES*LANE_W-1:0]   mem_dq_i,
  output logic [ADDR_W-1:0]         mem_addr_o,
  output logic [LANES-1:0]          mem_cs_n_o,
  output logic [LANES-1:0]          mem_we_n_o,
  output logic                      mem_oe_n_o,
  output logic [LANES*LANE_W-1:0]   mem_dq_o,
  output logic                      mem_dq_oe_o,
  output logic [LANES*LANE_W-1:0]   rdata_o,
  output logic                      rvalid_o
);
  import sram_lane_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  mask_q, mask_nxt;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  cs_n_q, cs_n_d;
  logic [LANES-1:0]  we_n_q, we_n_d;
  logic              oe_n_q, oe_n_d;
  logic              dq_oe_q, dq_oe_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q;
  logic              cs_act, we_act;
  logic              wdata_en;
  logic              overlap;

  assign mask_nxt = accept_i ? mask_i : mask_q;
  assign wdata_en = accept_i & wr_d_i;

  // request hold registers: loaded only on an accepted request, in idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      mask_q <= '0;
    end else if (accept_i) begin
      addr_q <= addr_i;
      mask_q <= mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdata_q <= '0;
    end else if (wdata_en) begin
      wdata_q <= wdata_i;
    end
  end

  // strobes are registered from the sequencer's next phase so pins are glitch free
  always_comb begin
    cs_act  = (phase_d_i == PH_PULSE) | (phase_d_i == PH_ACCESS);
    we_act  = (phase_d_i == PH_PULSE);
    cs_n_d  = cs_act ? ~mask_nxt : '1;
    oe_n_d  = (phase_d_i != PH_ACCESS);
    dq_oe_d = wr_d_i & ((phase_d_i == PH_SETUP) | (phase_d_i == PH_PULSE) |
                        (phase_d_i == PH_RECOV));
  end

  generate
    if (SPLIT_WE) begin : g_we_lane
      assign we_n_d = we_act ? ~mask_nxt : '1;
    end else begin : g_we_shared
      assign we_n_d = {LANES{~we_act}};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_q  <= '1;
      we_n_q  <= '1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      cs_n_q  <= cs_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      dq_oe_q <= dq_oe_d;
    end
  end

  // read capture: unselected lanes are forced to zero
  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_rd_lane
      assign rdata_d[l*LANE_W +: LANE_W] = mask_q[l] ? mem_dq_i[l*LANE_W +: LANE_W]
                                                     : '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (capture_i) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
    end
  end

  assign overlap     = |(~cs_n_q & ~we_n_q);
  assign mem_addr_o  = addr_q;
  assign mem_cs_n_o  = cs_n_q;
  assign mem_we_n_o  = we_n_q;
  assign mem_oe_n_o  = oe_n_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;
  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;

  AST_ADDR_OUTSIDE_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_q) |-> (!overlap && !$past(overlap))); // R4
  AST_NO_DRIVE_WHILE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_q |-> oe_n_q); // R8
  AST_TURNAROUND_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_q |=> !dq_oe_q); // R8
  AST_READ_WE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_q |-> (&we_n_q)); // R5
  AST_RVALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_q |=> !rvalid_q); // R5
  AST_LANE_GROUPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(~cs_n_q) <= 2) || ($countones(~cs_n_q) == LANES)); // R2
  AST_WE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&we_n_q) |-> !(&cs_n_q)); // R9
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W     = 17,
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int SETUP_CYC  = 1,
  parameter int PULSE_CYC  = 2,
  parameter int ACCESS_CYC = 2,
  parameter int RECOV_CYC  = 1,
  parameter bit SPLIT_WE   = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [1:0]              mode_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic                    ready_o,
  output logic                    err_o,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [LANES-1:0]        mem_cs_n_o,
  output logic [LANES-1:0]        mem_we_n_o,
  output logic                    mem_oe_n_o,
  output logic [LANES*LANE_W-1:0] mem_dq_o,
  output logic                    mem_dq_oe_o,
  input  logic [LANES*LANE_W-1:0] mem_dq_i
);
  import sram_lane_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       legal;
  logic       accept;
  logic       capture;
  logic       wr_d;
  phase_e     phase_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  sram_lane_decode #(
    .LANES (LANES)
  ) u_decode (
    .mode_i  (mode_i),
    .mask_i  (mask_i),
    .legal_o (legal)
  );

  sram_lane_seq #(
    .SETUP_CYC  (SETUP_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .RECOV_CYC  (RECOV_CYC)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .req_i     (req_i),
    .we_i      (we_i),
    .legal_i   (legal),
    .ready_o   (ready_o),
    .accept_o  (accept),
    .err_o     (err_o),
    .capture_o (capture),
    .phase_d_o (phase_d),
    .wr_d_o    (wr_d)
  );

  sram_lane_io #(
    .ADDR_W   (ADDR_W),
    .LANES    (LANES),
    .LANE_W   (LANE_W),
    .SPLIT_WE (SPLIT_WE)
  ) u_io (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .accept_i    (accept),
    .addr_i      (addr_i),
    .mask_i      (mask_i),
    .wdata_i     (wdata_i),
    .phase_d_i   (phase_d),
    .wr_d_i      (wr_d),
    .capture_i   (capture),
    .mem_dq_i    (mem_dq_i),
    .mem_addr_o  (mem_addr_o),
    .mem_cs_n_o  (mem_cs_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o)
  );

  AST_ERR_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_o |-> ((&mem_cs_n_o) && !mem_dq_oe_o)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ready_o && $past(ready_o)) |-> ((&mem_cs_n_o) && (&mem_we_n_o) && mem_oe_n_o)); // R1
endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;

  localparam int SETUP_N  = 1;
  localparam int PULSE_N  = 2;
  localparam int ACCESS_N = 2;
  localparam int RECOV_N  = 1;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        we;
  logic [1:0]  mode;
  logic [16:0] addr;
  logic [3:0]  mask;
  logic [31:0] wdata;
  logic        ready_o, err_o, rvalid_o;
  logic [31:0] rdata_o;
  logic [16:0] mem_addr_o;
  logic [3:0]  mem_cs_n_o, mem_we_n_o;
  logic        mem_oe_n_o, mem_dq_oe_o;
  logic [31:0] mem_dq_o, mem_dq_i;

  logic        sh_ready, sh_err, sh_rvalid, sh_oe_n, sh_dq_oe;
  logic [31:0] sh_rdata, sh_dq;
  logic [16:0] sh_addr;
  logic [3:0]  sh_cs_n, sh_we_n;

  int checks;
  int errors;
  int n_reads;
  int n_rvalid;
  int viol_addr;
  int viol_bus;
  int viol_we;
  int shared_pulses;
  logic [31:0] exp_q[$];
  logic [31:0] exp_mem [0:63];
  logic [31:0] ram [0:63];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  sram_lane_ctrl #(
    .SETUP_CYC (SETUP_N), .PULSE_CYC (PULSE_N), .ACCESS_CYC (ACCESS_N),
    .RECOV_CYC (RECOV_N), .SPLIT_WE (1'b1)
  ) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .mode_i (mode),
    .addr_i (addr), .mask_i (mask), .wdata_i (wdata), .ready_o (ready_o),
    .err_o (err_o), .rdata_o (rdata_o), .rvalid_o (rvalid_o),
    .mem_addr_o (mem_addr_o), .mem_cs_n_o (mem_cs_n_o), .mem_we_n_o (mem_we_n_o),
    .mem_oe_n_o (mem_oe_n_o), .mem_dq_o (mem_dq_o), .mem_dq_oe_o (mem_dq_oe_o),
    .mem_dq_i (mem_dq_i)
  );

  // shared write-enable variant, same stimulus, only its strobes are observed
  sram_lane_ctrl #(
    .SETUP_CYC (SETUP_N), .PULSE_CYC (PULSE_N), .ACCESS_CYC (ACCESS_N),
    .RECOV_CYC (RECOV_N), .SPLIT_WE (1'b0)
  ) dut_shared_i (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .mode_i (mode),
    .addr_i (addr), .mask_i (mask), .wdata_i (wdata), .ready_o (sh_ready),
    .err_o (sh_err), .rdata_o (sh_rdata), .rvalid_o (sh_rvalid),
    .mem_addr_o (sh_addr), .mem_cs_n_o (sh_cs_n), .mem_we_n_o (sh_we_n),
    .mem_oe_n_o (sh_oe_n), .mem_dq_o (sh_dq), .mem_dq_oe_o (sh_dq_oe),
    .mem_dq_i (mem_dq_i)
  );

  function automatic logic [31:0] init_word(input int i);
    return {8'(i), 8'h5A, 8'(i) ^ 8'hFF, 8'h3C};
  endfunction

  function automatic logic [31:0] expand(input logic [3:0] m);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = {8{m[l]}};
    return r;
  endfunction

  // RAM model: a lane reads out while selected with output enable low; floating lanes show A5
  always_comb begin
    for (int l = 0; l < 4; l++) begin
      if (!mem_cs_n_o[l] && !mem_oe_n_o && mem_we_n_o[l])
        mem_dq_i[l*8 +: 8] = ram[mem_addr_o[5:0]][l*8 +: 8];
      else
        mem_dq_i[l*8 +: 8] = 8'hA5;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) ram[i] <= init_word(i);
    end else begin
      for (int l = 0; l < 4; l++)
        if (!mem_cs_n_o[l] && !mem_we_n_o[l] && mem_dq_oe_o)
          ram[mem_addr_o[5:0]][l*8 +: 8] <= mem_dq_o[l*8 +: 8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected word per returned read
  always @(negedge clk) begin
    if (rst_n && rvalid_o) begin
      n_rvalid++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected rvalid", rdata_o, 32'h0);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rdata_o == e, "R5 read data", rdata_o, e);
      end
    end
  end

  // bus protocol monitor
  logic [16:0] prev_addr;
  logic        prev_ovl, prev_oe_n, prev_ok;
  always @(negedge clk) begin
    logic ovl;
    ovl = |(~mem_cs_n_o & ~mem_we_n_o);
    if (rst_n && prev_ok) begin
      if (mem_addr_o != prev_addr && (ovl || prev_ovl)) viol_addr++;
      if (mem_dq_oe_o && (!mem_oe_n_o || !prev_oe_n)) viol_bus++;
      if (mem_we_n_o != 4'hF) begin
        shared_pulses++;
        if (sh_we_n != 4'h0 || mem_we_n_o != mem_cs_n_o) viol_we++;
      end else if (sh_we_n != 4'hF) begin
        viol_we++;
      end
    end
    prev_addr = mem_addr_o;
    prev_ovl  = ovl;
    prev_oe_n = mem_oe_n_o;
    prev_ok   = rst_n;
  end

  task automatic check_idle(input string tag);
    chk(mem_cs_n_o == 4'hF && mem_we_n_o == 4'hF && mem_oe_n_o && !mem_dq_oe_o && ready_o,
        tag, {mem_cs_n_o, mem_we_n_o, 21'd0, mem_oe_n_o, mem_dq_oe_o, ready_o},
        {4'hF, 4'hF, 21'd0, 1'b1, 1'b0, 1'b1});
  endtask

  // driver: called at a negedge with the controller idle; returns at an idle negedge
  task automatic do_op(input logic w, input logic [1:0] md, input logic [16:0] a,
                       input logic [3:0] m, input logic [31:0] d, input bit bad);
    bit ok;
    req = 1'b1; we = w; mode = md; addr = a; mask = m; wdata = d;
    if (!bad && !w) begin
      exp_q.push_back(exp_mem[a[5:0]] & expand(m));
      n_reads++;
    end
    if (!bad && w)
      for (int l = 0; l < 4; l++)
        if (m[l]) exp_mem[a[5:0]][l*8 +: 8] = d[l*8 +: 8];
    @(negedge clk);
    req = 1'b0;
    if (bad) begin
      chk(err_o && mem_cs_n_o == 4'hF && mem_we_n_o == 4'hF && !mem_dq_oe_o,
          "R7 refused request", {err_o, 23'd0, mem_cs_n_o, mem_we_n_o},
          {1'b1, 23'd0, 4'hF, 4'hF});
      @(negedge clk);
      chk(!err_o, "R7 error pulse length", {31'd0, err_o}, 32'd0);
      check_idle("R1 idle after refusal");
      return;
    end
    ok = 1'b1;
    for (int i = 0; i < SETUP_N; i++) begin
      if (mem_cs_n_o != 4'hF || mem_we_n_o != 4'hF || !mem_oe_n_o ||
          mem_addr_o != a || mem_dq_oe_o != w) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, w ? "R3 write setup" : "R5 read setup", {15'd0, mem_addr_o}, {15'd0, a});
    ok = 1'b1;
    for (int i = 0; i < (w ? PULSE_N : ACCESS_N); i++) begin
      if (w) begin
        if (mem_cs_n_o != ~m || mem_we_n_o != ~m || !mem_oe_n_o || !mem_dq_oe_o ||
            mem_dq_o != d) ok = 1'b0;
      end else begin
        if (mem_cs_n_o != ~m || mem_we_n_o != 4'hF || mem_oe_n_o || mem_dq_oe_o)
          ok = 1'b0;
      end
      @(negedge clk);
    end
    chk(ok, w ? "R3 write pulse" : "R5 read access", {24'd0, mem_cs_n_o, mem_we_n_o},
        {24'd0, ~m, w ? ~m : 4'hF});
    ok = 1'b1;
    for (int i = 0; i < RECOV_N; i++) begin
      if (mem_cs_n_o != 4'hF || mem_we_n_o != 4'hF || !mem_oe_n_o ||
          mem_dq_oe_o != w) ok = 1'b0;
      if (i == 0 && !w && !rvalid_o) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, w ? "R3 write recovery" : "R5 read recovery and rvalid",
        {31'd0, rvalid_o}, 32'd0);
    check_idle("R1 idle between transactions");
  endtask

  initial begin
    checks = 0; errors = 0; n_reads = 0; n_rvalid = 0;
    viol_addr = 0; viol_bus = 0; viol_we = 0; shared_pulses = 0;
    prev_ok = 1'b0; prev_addr = '0; prev_ovl = 1'b0; prev_oe_n = 1'b1;
    req = 1'b0; we = 1'b0; mode = 2'd0; addr = '0; mask = '0; wdata = '0;
    for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 reset state");
    chk(!rvalid_o && !err_o, "R1 no pulses after reset", {30'd0, rvalid_o, err_o}, 32'd0);

    // R2 R3 word write then word read
    do_op(1'b1, 2'd2, 17'd5, 4'hF, 32'h11223344, 1'b0);
    do_op(1'b0, 2'd2, 17'd5, 4'hF, 32'h0, 1'b0);
    // R6 byte lanes one by one, then whole word
    do_op(1'b1, 2'd0, 17'd6, 4'h1, 32'hDEAD_BE01, 1'b0);
    do_op(1'b1, 2'd0, 17'd6, 4'h4, 32'h0077_0000, 1'b0);
    do_op(1'b0, 2'd2, 17'd6, 4'hF, 32'h0, 1'b0);
    do_op(1'b1, 2'd0, 17'd6, 4'h2, 32'h0000_9900, 1'b0);
    do_op(1'b1, 2'd0, 17'd6, 4'h8, 32'hAB00_0000, 1'b0);
    do_op(1'b0, 2'd2, 17'd6, 4'hF, 32'h0, 1'b0);
    // R5 byte and half reads: unselected lanes zero
    do_op(1'b0, 2'd0, 17'd5, 4'h4, 32'h0, 1'b0);
    do_op(1'b0, 2'd1, 17'd9, 4'hC, 32'h0, 1'b0);
    // R6 half-word write to the high pair keeps the low pair
    do_op(1'b1, 2'd1, 17'd7, 4'hC, 32'hCAFE_0000, 1'b0);
    do_op(1'b0, 2'd2, 17'd7, 4'hF, 32'h0, 1'b0);
    do_op(1'b1, 2'd1, 17'd8, 4'h3, 32'h0000_F00D, 1'b0);
    do_op(1'b0, 2'd2, 17'd8, 4'hF, 32'h0, 1'b0);
    // R7 refused requests
    do_op(1'b1, 2'd0, 17'd5, 4'h3, 32'hFFFF_FFFF, 1'b1);
    do_op(1'b1, 2'd1, 17'd5, 4'h6, 32'hFFFF_FFFF, 1'b1);
    do_op(1'b1, 2'd2, 17'd5, 4'h7, 32'hFFFF_FFFF, 1'b1);
    do_op(1'b1, 2'd3, 17'd5, 4'hF, 32'hFFFF_FFFF, 1'b1);
    do_op(1'b0, 2'd0, 17'd5, 4'h0, 32'h0, 1'b1);
    do_op(1'b0, 2'd2, 17'd5, 4'hF, 32'h0, 1'b0);
    // R8 read immediately followed by a write to the same word
    do_op(1'b0, 2'd2, 17'd10, 4'hF, 32'h0, 1'b0);
    do_op(1'b1, 2'd2, 17'd10, 4'hF, 32'h5555_AAAA, 1'b0);
    do_op(1'b0, 2'd1, 17'd10, 4'h3, 32'h0, 1'b0);
    do_op(1'b1, 2'd0, 17'd10, 4'h2, 32'h0000_3300, 1'b0);
    do_op(1'b0, 2'd2, 17'd10, 4'hF, 32'h0, 1'b0);
    // R4 full-width address
    do_op(1'b1, 2'd2, 17'h1FFC3, 4'hF, 32'h0BAD_F00D, 1'b0);
    do_op(1'b0, 2'd2, 17'h1FFC3, 4'hF, 32'h0, 1'b0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && n_rvalid == n_reads, "R5 every read returned once",
        32'(n_rvalid), 32'(n_reads));
    chk(viol_addr == 0, "R4 address moved during a write overlap", 32'(viol_addr), 32'd0);
    chk(viol_bus == 0, "R8 driver on during or right after a read", 32'(viol_bus), 32'd0);
    chk(viol_we == 0 && shared_pulses > 0, "R9 write enable layout", 32'(viol_we), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule